// File: doc/BRIEF.md
# Converter Serial Command and Result Port

This block is the digital serial port of a sampling analog-to-digital converter, as seen from the device side. During one select-low exchange, a host clocks a mode and address command into the device and clocks out the result of the previous conversion. The result is 13 bits wide: a sign bit plus 12 magnitude bits, in two's complement. A negative differential input therefore gives a valid negative code. The conversion engine is outside this block. It supplies a parallel result and an end-of-conversion strobe.

The block runs entirely on a fast system clock. The serial clock, select, end-of-conversion and serial data pins are each passed through a two-flop synchroniser and an edge detector. The system clock must run at least eight times faster than the serial clock.

The first result bit is not launched by a serial clock edge. It is launched either by select falling or, when select stays low, by end-of-conversion rising. Each falling serial clock edge after that moves the output to the next bit. The latched command and a one-cycle valid strobe go to the surrounding control logic.

Top module: `conv_serial_port`

## Requirements
- R1: While select is low, each rising serial clock edge shifts the data-in bit into an 8-bit command register, entering at the LSB. After exactly 8 rising edges, the first bit sent therefore sits in cmd[7].
- R2: When select rises after 8 or more rising serial clock edges in the frame, the last 8 bits shifted in are latched on `cmd`, and `cmd_valid` is high for exactly one system clock.
- R3: When select rises after fewer than 8 rising serial clock edges, the command is discarded: `cmd` keeps its earlier value and `cmd_valid` does not pulse.
- R4: A falling edge of select loads the most recently completed result, a 13-bit two's-complement word, and presents its sign bit (bit 12) on `sdo` before any serial clock edge.
- R5: While select is low, each falling serial clock edge moves `sdo` on by one bit: after the sign bit come bits 11 down to 0, MSB first. From the 13th falling edge on, `sdo` holds 0 until the next frame.
- R6: If select stays low and no frame is in progress, a rising end-of-conversion edge loads the new result and presents its sign bit on `sdo`. Later bits then follow R5.
- R7: A rising end-of-conversion edge during a frame only updates the holding register. The word being shifted out is unchanged, and the next frame sends the new result.
- R8: `sdo_oe` is high exactly while `cs_n` is low, with no system clock delay. It is low while `cs_n` is high.
- R9: `proto_err` pulses for one system clock when select falls while the serial clock is high. It stays low on every select fall that occurs with the serial clock low.
- R10: An output response to a pin event (first bit, next bit, command strobe) appears no later than the third rising system clock edge after the pin changes.
- R11: After reset, `cmd` is 0, `cmd_valid` is 0, `proto_err` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| sdi | input | 1 | Serial command data in |
| eoc | input | 1 | End-of-conversion strobe from the conversion engine |
| result | input | 13 | Parallel conversion result, sign plus 12 bits, two's complement |
| sdo | output | 1 | Serial result data out |
| sdo_oe | output | 1 | Output enable for the external tri-state driver of `sdo` |
| cmd | output | 8 | Latched command word (mux address and mode) |
| cmd_valid | output | 1 | One-cycle strobe when `cmd` is updated |
| proto_err | output | 1 | One-cycle strobe: select fell while the serial clock was high |

## Verification
The bench targets these corner cases, and for each one names the failure a wrong design would show:
- Frames with exactly 7, 8 and more than 8 rising edges. An off-by-one in the edge count either latches a short command or drops a full one. Keeping the wrong window latches the first 8 bits instead of the last 8.
- Select held low across an end-of-conversion. If the event is not launched, `sdo` stays at 0. An end-of-conversion arriving mid-frame must not reload the shift word, or the rest of the frame would suddenly carry the new word's bits.
- Negative results, so the sign bit is 1. These check that the first bit comes from the select edge and not from the first clock edge. A design that lost the first bit would shift every later bit by one position.
- A select fall with the serial clock high. This must raise the error pulse, and no normal frame may raise it.

// File: rtl/csp_pkg.sv
`timescale 1ns/1ps
package csp_pkg;
  localparam int CSP_CMD_W     = 8;
  localparam int CSP_RES_W     = 13;
  localparam int CSP_SYNC_DEPTH = 2;

  // edge pair produced for one synchronised pin
  typedef struct packed {
    logic rise;
    logic fall;
  } csp_edge_t;
endpackage

// File: rtl/csp_sync.sv
`timescale 1ns/1ps
module csp_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/csp_cmd_capture.sv
`timescale 1ns/1ps
module csp_cmd_capture #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selected,
  input  logic             shift_evt,
  input  logic             din,
  input  logic             open_evt,
  input  logic             close_evt,
  output logic [CMD_W-1:0] cmd,
  output logic             cmd_valid,
  output logic             cmd_full
);
  localparam int SEEN_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0]  shreg;
  logic [SEEN_W-1:0] seen;

  // new bit enters at the LSB, oldest bit moves toward the MSB
  function automatic logic [CMD_W-1:0] push_bit(input logic [CMD_W-1:0] cur,
                                                 input logic b);
    return {cur[CMD_W-2:0], b};
  endfunction

  function automatic logic [SEEN_W-1:0] bump(input logic [SEEN_W-1:0] n);
    return (n == SEEN_W'(CMD_W)) ? n : n + SEEN_W'(1);
  endfunction

  assign cmd_full = (seen == SEEN_W'(CMD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      seen      <= '0;
      cmd       <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (open_evt) begin
        seen <= '0;
      end else if (close_evt) begin
        seen <= '0;
        if (cmd_full) begin
          cmd       <= shreg;
          cmd_valid <= 1'b1;
        end
      end else if (selected && shift_evt) begin
        shreg <= push_bit(shreg, din);
        seen  <= bump(seen);
      end
    end
  end
endmodule

// File: rtl/csp_result_shifter.sv
`timescale 1ns/1ps
module csp_result_shifter #(
  parameter int RES_W = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         selected,
  input  logic [RES_W-1:0]             res_in,
  input  logic                         eoc_rise,
  input  logic                         open_evt,
  input  logic                         close_evt,
  input  logic                         step_evt,
  output logic                         bit_out,
  output logic [$clog2(RES_W+1)-1:0]   bits_left,
  output logic                         frame_active
);
  localparam int CNT_W = $clog2(RES_W + 1);

  logic [RES_W-1:0] held;
  logic [RES_W-1:0] word;
  logic             launch_eoc;

  // shift toward the MSB, filling with zeros so the tail reads 0
  function automatic logic [RES_W-1:0] advance(input logic [RES_W-1:0] w);
    return {w[RES_W-2:0], 1'b0};
  endfunction

  assign frame_active = (bits_left != '0);
  assign launch_eoc   = eoc_rise && selected && !frame_active && !open_evt;
  assign bit_out      = word[RES_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (eoc_rise) held <= res_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word      <= '0;
      bits_left <= '0;
    end else if (close_evt) begin
      word      <= '0;
      bits_left <= '0;
    end else if (open_evt) begin
      word      <= eoc_rise ? res_in : held;
      bits_left <= CNT_W'(RES_W);
    end else if (launch_eoc) begin
      word      <= res_in;
      bits_left <= CNT_W'(RES_W);
    end else if (selected && step_evt && frame_active) begin
      word      <= advance(word);
      bits_left <= bits_left - CNT_W'(1);
    end
  end
endmodule

// File: rtl/conv_serial_port.sv
`timescale 1ns/1ps
module conv_serial_port #(
  parameter int CMD_W      = csp_pkg::CSP_CMD_W,
  parameter int RES_W      = csp_pkg::CSP_RES_W,
  parameter int SYNC_DEPTH = csp_pkg::CSP_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             eoc,
  input  logic [RES_W-1:0] result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [CMD_W-1:0] cmd,
  output logic             cmd_valid,
  output logic             proto_err
);
  import csp_pkg::*;

  localparam int CNT_W = $clog2(RES_W + 1);

  // synchronised pins: {sdi, eoc, cs_n, sclk}; cs_n idles high
  logic [3:0] pins_s;
  logic       sclk_lvl, cs_lvl, eoc_lvl, sdi_lvl;
  logic       sclk_q, cs_q, eoc_q;
  csp_edge_t  sclk_e, cs_e;

  // named internal events, also read by the bound checker
  logic             sclk_rise_evt, sclk_fall_evt;
  logic             cs_rise_evt, cs_fall_evt, eoc_rise_evt;
  logic             selected, cmd_full, frame_active;
  logic [CNT_W-1:0] bits_left;

  csp_sync #(.WIDTH(4), .STAGES(SYNC_DEPTH), .RST_VAL(4'b0010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sdi, eoc, cs_n, sclk}),
    .dout (pins_s)
  );

  assign sclk_lvl = pins_s[0];
  assign cs_lvl   = pins_s[1];
  assign eoc_lvl  = pins_s[2];
  assign sdi_lvl  = pins_s[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      eoc_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_lvl;
      cs_q   <= cs_lvl;
      eoc_q  <= eoc_lvl;
    end
  end

  assign sclk_e = '{rise: sclk_lvl & ~sclk_q, fall: ~sclk_lvl & sclk_q};
  assign cs_e   = '{rise: cs_lvl & ~cs_q,     fall: ~cs_lvl & cs_q};

  assign sclk_rise_evt = sclk_e.rise;
  assign sclk_fall_evt = sclk_e.fall;
  assign cs_rise_evt   = cs_e.rise;
  assign cs_fall_evt   = cs_e.fall;
  assign eoc_rise_evt  = eoc_lvl & ~eoc_q;
  assign selected      = ~cs_lvl;

  csp_cmd_capture #(.CMD_W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .selected (selected),
    .shift_evt(sclk_rise_evt),
    .din      (sdi_lvl),
    .open_evt (cs_fall_evt),
    .close_evt(cs_rise_evt),
    .cmd      (cmd),
    .cmd_valid(cmd_valid),
    .cmd_full (cmd_full)
  );

  csp_result_shifter #(.RES_W(RES_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .selected    (selected),
    .res_in      (result),
    .eoc_rise    (eoc_rise_evt),
    .open_evt    (cs_fall_evt),
    .close_evt   (cs_rise_evt),
    .step_evt    (sclk_fall_evt),
    .bit_out     (sdo),
    .bits_left   (bits_left),
    .frame_active(frame_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= cs_fall_evt & sclk_lvl;
  end

  // enable follows the raw pin so the line is released at once
  assign sdo_oe = ~cs_n;
endmodule

// File: rtl/conv_serial_port_chk.sv
`timescale 1ns/1ps
module conv_serial_port_chk #(
  parameter int CMD_W = 8,
  parameter int RES_W = 13
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CMD_W-1:0]           cmd,
  input logic                       cmd_valid,
  input logic                       cmd_full,
  input logic                       cs_rise_evt,
  input logic                       cs_fall_evt,
  input logic                       sclk_fall_evt,
  input logic                       sclk_lvl,
  input logic                       eoc_rise_evt,
  input logic                       selected,
  input logic                       frame_active,
  input logic [$clog2(RES_W+1)-1:0] bits_left,
  input logic                       sdo,
  input logic                       proto_err
);
  localparam int CNT_W = $clog2(RES_W + 1);

  p_valid_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_valid_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise_evt && cmd_full));

  p_cmd_moves_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd) |-> cmd_valid);

  p_open_loads_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_evt |=> (bits_left == CNT_W'(RES_W)));

  p_step_counts_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall_evt && selected && frame_active && !cs_fall_evt && !cs_rise_evt)
      |=> (bits_left == $past(bits_left) - CNT_W'(1)));

  p_idle_sends_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !frame_active) |-> !sdo);

  p_eoc_idle_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_rise_evt && selected && !frame_active && !cs_rise_evt)
      |=> (bits_left == CNT_W'(RES_W)));

  p_err_on_bad_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall_evt && sclk_lvl) |=> proto_err);

  p_err_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cs_fall_evt && sclk_lvl));
endmodule

bind conv_serial_port conv_serial_port_chk #(.CMD_W(CMD_W), .RES_W(RES_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd          (cmd),
  .cmd_valid    (cmd_valid),
  .cmd_full     (cmd_full),
  .cs_rise_evt  (cs_rise_evt),
  .cs_fall_evt  (cs_fall_evt),
  .sclk_fall_evt(sclk_fall_evt),
  .sclk_lvl     (sclk_lvl),
  .eoc_rise_evt (eoc_rise_evt),
  .selected     (selected),
  .frame_active (frame_active),
  .bits_left    (bits_left),
  .sdo          (sdo),
  .proto_err    (proto_err)
);

// File: tb/conv_serial_port_test.sv
`timescale 1ns/1ps
module conv_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        eoc = 1'b0;
  logic [12:0] result = '0;
  logic        sdo, sdo_oe, cmd_valid, proto_err;
  logic [7:0]  cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          vpulses = 0;
  int          epulses = 0;
  logic [7:0]  held_cmd = '0;   // last command the bench expects latched
  logic [12:0] held_res = '0;   // last result the bench expects held
  logic [7:0]  cmd_track = '0;  // bench model of the command shift register
  int          rises = 0;
  int          bitpos = 0;

  conv_serial_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .eoc(eoc), .result(result), .sdo(sdo), .sdo_oe(sdo_oe),
    .cmd(cmd), .cmd_valid(cmd_valid), .proto_err(proto_err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (cmd_valid) vpulses++;
    if (proto_err) epulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected bit after k falling edges of the frame word
  function automatic logic exp_bit(input logic [12:0] w, input int k);
    return (k <= 12) ? w[12-k] : 1'b0;
  endfunction

  function automatic logic [7:0] exp_push(input logic [7:0] c, input logic b);
    return {c[6:0], b};
  endfunction

  task automatic pulse_eoc(input logic [12:0] v);
    result = v;
    eoc = 1'b1;
    waitn(4);
    eoc = 1'b0;
    waitn(4);
    held_res = v;
  endtask

  task automatic sel_open(input logic [12:0] w);
    int e0;
    e0 = epulses;
    cs_n = 1'b0;
    rises = 0;
    bitpos = 0;
    #1;
    chk("R8 oe on select low", sdo_oe, 1'b1);
    waitn(3);
    chk("R4/R10 sign bit on select fall", sdo, w[12]);
    waitn(3);
    chk("R9 no error on clean open", epulses - e0, 0);
  endtask

  task automatic shift_bits(input logic [12:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom);
      sclk = 1'b1;
      cmd_track = exp_push(cmd_track, sdi);
      rises++;
      waitn(8);
      sclk = 1'b0;
      bitpos++;
      waitn(3);
      chk("R5/R10 next bit on falling sclk", sdo, exp_bit(w, bitpos));
      waitn(5);
    end
  endtask

  task automatic sel_close();
    int v0;
    v0 = vpulses;
    cs_n = 1'b1;
    #1;
    chk("R8 oe off on select high", sdo_oe, 1'b0);
    waitn(6);
    if (rises >= 8) begin
      held_cmd = cmd_track;
      chk("R2 one valid pulse", vpulses - v0, 1);
      chk("R1/R2 latched last 8 bits", cmd, held_cmd);
    end else begin
      chk("R3 no valid pulse on short frame", vpulses - v0, 0);
      chk("R3 command kept", cmd, held_cmd);
    end
  endtask

  task automatic frame(input int n);
    logic [12:0] w;
    w = held_res;
    sel_open(w);
    shift_bits(w, n);
    sel_close();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] w1, w2;
    int seed;
    seed = $urandom(32'd2718);
    waitn(4);
    chk("R11 cmd after reset", cmd, 8'h00);
    chk("R11 cmd_valid after reset", cmd_valid, 1'b0);
    chk("R11 proto_err after reset", proto_err, 1'b0);
    chk("R11 sdo after reset", sdo, 1'b0);
    chk("R8 oe off after reset", sdo_oe, 1'b0);
    rst_n = 1'b1;
    waitn(4);

    // R4 R5: negative result, exactly 8 edges latches a command (R1 R2)
    pulse_eoc(13'h1A5C);
    frame(8);
    // R3: seven edges is short
    pulse_eoc(13'h0F3B);
    frame(7);
    // full frame plus tail zeros, longer command (R2 last 8)
    pulse_eoc(13'h1001);
    frame(16);

    // R6: select held low across an end-of-conversion
    w1 = held_res;
    sel_open(w1);
    shift_bits(w1, 13);
    w2 = 13'h1C3E;
    pulse_eoc(w2);
    chk("R6 sign bit on eoc while selected", sdo, w2[12]);
    bitpos = 0;
    shift_bits(w2, 13);
    sel_close();

    // R7: eoc mid-frame leaves current word intact
    pulse_eoc(13'h0AAA);
    w1 = held_res;
    sel_open(w1);
    shift_bits(w1, 5);
    pulse_eoc(13'h1555);
    shift_bits(w1, 9);
    sel_close();
    w2 = held_res;
    sel_open(w2);
    chk("R7 next frame sends updated result", sdo, w2[12]);
    shift_bits(w2, 13);
    sel_close();

    // R9: select falls while sclk is high
    begin
      int e0;
      e0 = epulses;
      sclk = 1'b1;
      waitn(8);
      cs_n = 1'b0;
      waitn(6);
      chk("R9 error pulse on select fall with sclk high", epulses - e0, 1);
      sclk = 1'b0;
      waitn(8);
      rises = 0;
      sel_close();
    end

    // random frames
    for (int f = 0; f < 30; f++) begin
      pulse_eoc(13'($urandom));
      frame(int'($urandom_range(0, 20)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule